// File: doc/BRIEF.md
# Memory Controller Configuration and Boot Remap Register

This block holds the one control word of a memory controller and also drives the behaviour that word configures. Software reads and writes it over a simple single-cycle register bus at one fixed word address. Three things follow from its contents. The first is how the lowest 256 MB of the address space is decoded. The second is whether the controller core drops into idle after a stretch with no requests. The third is what appears on the external SDRAM clock pin.

After reset, the bottom address area belongs to the boot ROM. Boot code sets the remap bit, and the area is then released so that the other memory decoders can claim it through their own base addresses. Clearing the bit gives the area back to the boot ROM. When automatic idle is allowed, the controller goes idle once a fixed number of consecutive clocks have passed with no memory request. A request that arrives while the controller is idle is granted in the same cycle, and the controller is active again from the next clock edge. The clock pin carries either the SDRAM clock or a software-driven level. Two further bits enable the SDRAM controller and the debug port.

Top module: `memcfg_ctrl`

## Requirements
- R1: After reset every field is 0. A read returns 0, boot_rom_sel is asserted for area-0 requests, core idle policy is automatic, and sdram_en and jtag_en are 0.
- R2: The control word is at address 0xF0000008. Bit 0 is remap, bit 1 is the pin level, bit 2 is keep-awake, bit 3 is pin select, bit 4 is SDRAM enable and bit 5 is debug enable. A read returns these six bits, with bits 31:6 reading 0. Written values in bits 31:6 are ignored, and writes to any other address leave the word unchanged.
- R3: While remap is 0, a valid request with req_addr[31:28] == 0 asserts boot_rom_sel and leaves area0_release low.
- R4: While remap is 1, such a request leaves boot_rom_sel low and asserts area0_release. A request outside area 0, or a cycle without req_valid, asserts neither output.
- R5: Writing remap back to 0 returns area 0 to the boot ROM from the cycle after the write.
- R6: With keep-awake 0, core_idle rises on the clock edge that ends the 4th consecutive cycle without req_valid, and it stays 0 before that edge.
- R7: req_grant follows req_valid in the same cycle even while idle. core_idle is 0 from the edge after any request cycle.
- R8: With keep-awake 1, core_idle stays 0 regardless of requests. Setting keep-awake while idle clears core_idle on the following edge.
- R9: With pin select 0, sd_clk_pin equals sdram_clk_in. With pin select 1, it equals the stored pin-level bit.
- R10: sdram_en and jtag_en equal bit 4 and bit 5 of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Register bus byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading the word |
| req_valid | input | 1 | Memory request strobe |
| req_addr | input | 32 | Memory request address |
| sdram_clk_in | input | 1 | SDRAM clock from the clock generator |
| req_grant | output | 1 | Request accepted this cycle |
| boot_rom_sel | output | 1 | Request decodes to the boot ROM |
| area0_release | output | 1 | Area-0 request left to other decoders |
| core_idle | output | 1 | Controller core is idle |
| sdram_en | output | 1 | SDRAM controller enable |
| jtag_en | output | 1 | Debug port enable |
| sd_clk_pin | output | 1 | Value for the external SDRAM clock pin |

## Verification
The area decode is tried with addresses at the bottom and top of area 0 and just above it, with and without req_valid, and with remap set, cleared and set again. This separates a correct top-nibble compare from an off-by-one boundary and from a decode that ignores the remap bit. The idle timer is driven with request-free runs sampled at three and at four edges, with a request that lands while the core is idle, and with keep-awake set both before and during idle. These runs expose a timer that is one cycle early or late, and a wake-up that costs an extra cycle. The pin multiplexer is exercised with both levels of the SDRAM clock and of the pin-level bit, so that a swapped select is visible.

// File: rtl/memcfg_pkg.sv
// Package: shared field layout and power state for the memory configuration block.
// Assumes the bit order of cfg_t matches the software-visible register layout.
package memcfg_pkg;

    localparam int unsigned CFG_FIELDS = 6;

    // Packed from MSB (bit 5) down to LSB (bit 0).
    typedef struct packed {
        logic dbg_enable;    // bit 5
        logic sdram_enable;  // bit 4
        logic pin_select;    // bit 3
        logic keep_awake;    // bit 2
        logic pin_level;     // bit 1
        logic remap;         // bit 0
    } cfg_t;

    typedef enum logic {
        PWR_ACTIVE = 1'b0,
        PWR_IDLE   = 1'b1
    } pwr_state_t;

endpackage

// File: rtl/memcfg_regs.sv
// Module: memcfg_regs
// Holds the control word and serves single-cycle reads and writes at one address.
// Assumes bus_sel/bus_wr are sampled on every rising edge; reads are combinational.
module memcfg_regs
    import memcfg_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 32,
    parameter int unsigned        DATA_W   = 32,
    parameter logic [ADDR_W-1:0]  CFG_ADDR = 32'hF000_0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output cfg_t              cfg
);

    localparam int unsigned PAD_W = DATA_W - CFG_FIELDS;

    logic addr_hit;
    logic cfg_we;
    cfg_t cfg_q;

    // Purpose: decode an access aimed at the control word.
    always_comb begin
        addr_hit = bus_sel && (bus_addr == CFG_ADDR);
        cfg_we   = addr_hit && bus_wr;
    end

    // Purpose: store the defined fields; upper data bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_t'(bus_wdata[CFG_FIELDS-1:0]);
        end
    end

    // Purpose: return the stored word zero-extended on a read, else zero.
    always_comb begin
        bus_rdata = '0;
        if (addr_hit && !bus_wr) begin
            bus_rdata = {{PAD_W{1'b0}}, cfg_q};
        end
    end

    assign cfg = cfg_q;

    // R1: the word is clear in the first cycle out of reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0));

    // R2: a write lands its low six bits and nothing else.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(bus_wdata[CFG_FIELDS-1:0])));

    // R2: with no write to the word, the word holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/memcfg_area_decode.sv
// Module: memcfg_area_decode
// Decides whether a request to the lowest address area goes to the boot ROM
// or is released to the other memory decoders, based on the remap bit.
// Assumes the area is the block of addresses whose top AREA_BITS bits are zero.
module memcfg_area_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned AREA_BITS = 4
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              remap,
    output logic              boot_rom_sel,
    output logic              area0_release
);

    localparam int unsigned TOP_LSB = ADDR_W - AREA_BITS;

    logic in_area0;

    // Purpose: detect a live request inside area 0.
    always_comb begin
        in_area0 = req_valid && (req_addr[ADDR_W-1:TOP_LSB] == '0);
    end

    // Purpose: route the area-0 request by the remap state.
    always_comb begin
        boot_rom_sel  = in_area0 && !remap;
        area0_release = in_area0 && remap;
    end

    // R4: the boot ROM and the released path never both claim a request.
    always_comb begin
        a_r4_exclusive: assert (!(boot_rom_sel && area0_release));
    end

endmodule

// File: rtl/memcfg_idle.sv
// Module: memcfg_idle
// Tracks request-free cycles and puts the controller core into idle after
// IDLE_CYCLES of them, unless keep_awake is set. Requests are granted at once.
// Assumes req_valid is a per-cycle strobe.
module memcfg_idle
    import memcfg_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic keep_awake,
    output logic req_grant,
    output logic core_idle
);

    localparam int unsigned CNT_W = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_QUIET = CNT_W'(IDLE_CYCLES - 1);

    pwr_state_t         state_q;
    logic [CNT_W-1:0]   quiet_cnt;

    // Purpose: count request-free cycles and step the power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PWR_ACTIVE;
            quiet_cnt <= '0;
        end else if (req_valid || keep_awake) begin
            state_q   <= PWR_ACTIVE;
            quiet_cnt <= '0;
        end else if (state_q == PWR_ACTIVE) begin
            if (quiet_cnt == LAST_QUIET) begin
                state_q   <= PWR_IDLE;
                quiet_cnt <= '0;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    // Purpose: grant in the same cycle and expose the power state.
    always_comb begin
        req_grant = req_valid;
        core_idle = (state_q == PWR_IDLE);
    end

    // Checker counter: length of the current quiet run, saturating.
    logic [CNT_W:0] chk_run;
    always_ff @(posedge clk) begin
        if (!rst_n || req_valid || keep_awake) begin
            chk_run <= '0;
        end else if (chk_run != (CNT_W+1)'(IDLE_CYCLES)) begin
            chk_run <= chk_run + 1'b1;
        end
    end

    // R6: idle exactly when the quiet run has reached its length.
    a_r6_idle_exact: assert property (@(posedge clk) disable iff (!rst_n)
        core_idle == (chk_run == (CNT_W+1)'(IDLE_CYCLES)));

    // R7: any request leaves the core active from the next edge.
    a_r7_wake_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !core_idle);

    // R8: keep-awake forbids idle on the following edge.
    a_r8_keep_awake: assert property (@(posedge clk) disable iff (!rst_n)
        keep_awake |=> !core_idle);

endmodule

// File: rtl/memcfg_pin_mux.sv
// Module: memcfg_pin_mux
// Chooses what drives the external SDRAM clock pin: the clock or a software level.
// Assumes both inputs are glitch-free at the pin's needs; purely combinational.
module memcfg_pin_mux (
    input  logic pin_select,
    input  logic pin_level,
    input  logic sdram_clk_in,
    output logic sd_clk_pin
);

    // Purpose: pick the pin source.
    always_comb begin
        sd_clk_pin = pin_select ? pin_level : sdram_clk_in;
    end

endmodule

// File: rtl/memcfg_ctrl.sv
// Module: memcfg_ctrl (top)
// Control register of a memory controller plus the logic it steers: area-0 boot
// remap decode, automatic idle, SDRAM clock pin source, and two enables.
// Assumes a single clock domain and a synchronous active-low reset.
module memcfg_ctrl
    import memcfg_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 32,
    parameter int unsigned        DATA_W      = 32,
    parameter logic [ADDR_W-1:0]  CFG_ADDR    = 32'hF000_0008,
    parameter int unsigned        AREA_BITS   = 4,
    parameter int unsigned        IDLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              sdram_clk_in,
    output logic              req_grant,
    output logic              boot_rom_sel,
    output logic              area0_release,
    output logic              core_idle,
    output logic              sdram_en,
    output logic              jtag_en,
    output logic              sd_clk_pin
);

    cfg_t cfg;

    memcfg_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    memcfg_area_decode #(
        .ADDR_W    (ADDR_W),
        .AREA_BITS (AREA_BITS)
    ) u_decode (
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .remap         (cfg.remap),
        .boot_rom_sel  (boot_rom_sel),
        .area0_release (area0_release)
    );

    memcfg_idle #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .keep_awake (cfg.keep_awake),
        .req_grant  (req_grant),
        .core_idle  (core_idle)
    );

    memcfg_pin_mux u_pin (
        .pin_select   (cfg.pin_select),
        .pin_level    (cfg.pin_level),
        .sdram_clk_in (sdram_clk_in),
        .sd_clk_pin   (sd_clk_pin)
    );

    // Purpose: drive the enables straight from the stored word.
    always_comb begin
        sdram_en = cfg.sdram_enable;
        jtag_en  = cfg.dbg_enable;
    end

    // Observation of a bus write to the word, for the properties below.
    logic obs_cfg_wr;
    always_comb begin
        obs_cfg_wr = bus_sel && bus_wr && (bus_addr == CFG_ADDR);
    end

    // R4: after remap is written to 1, the boot ROM is not selected.
    a_r4_remap_release: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_cfg_wr && bus_wdata[0]) |=> !boot_rom_sel);

    // R9: selecting the software level puts the written level on the pin.
    a_r9_pin_level: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_cfg_wr && bus_wdata[3]) |=> (sd_clk_pin == $past(bus_wdata[1])));

    // R10: enables follow the written bits.
    a_r10_enables: assert property (@(posedge clk) disable iff (!rst_n)
        obs_cfg_wr |=> ((sdram_en == $past(bus_wdata[4])) && (jtag_en == $past(bus_wdata[5]))));

endmodule

// File: tb/memcfg_ctrl_bench.sv
`timescale 1ns/1ps
module memcfg_ctrl_bench;

    localparam logic [31:0] CFG_ADDR = 32'hF000_0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        sdram_clk_in = 1'b0;
    logic        req_grant, boot_rom_sel, area0_release, core_idle;
    logic        sdram_en, jtag_en, sd_clk_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    memcfg_ctrl u_memcfg_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .sdram_clk_in(sdram_clk_in),
        .req_grant(req_grant), .boot_rom_sel(boot_rom_sel),
        .area0_release(area0_release), .core_idle(core_idle),
        .sdram_en(sdram_en), .jtag_en(jtag_en), .sd_clk_pin(sd_clk_pin)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic v, input logic exp_boot,
                         input logic exp_rel, input string req);
        req_valid = v; req_addr = a;
        #1;
        check({req, " boot_rom_sel"}, {31'd0, boot_rom_sel}, {31'd0, exp_boot});
        check({req, " area0_release"}, {31'd0, area0_release}, {31'd0, exp_rel});
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(CFG_ADDR, d);
        check("R1 read after reset", d, 32'h0);
        check("R1 sdram_en", {31'd0, sdram_en}, 32'h0);
        check("R1 jtag_en", {31'd0, jtag_en}, 32'h0);
        @(negedge clk);
        probe(32'h0000_0100, 1'b1, 1'b1, 1'b0, "R1");
    endtask

    task automatic t_readback();
        logic [31:0] d;
        bus_write(CFG_ADDR, 32'hFFFF_FFC0 | 32'h16);
        bus_read(CFG_ADDR, d);
        check("R2 upper bits ignored", d, 32'h16);
        bus_write(32'hF000_000C, 32'h3F);
        bus_read(CFG_ADDR, d);
        check("R2 other address ignored", d, 32'h16);
        bus_write(CFG_ADDR, 32'h29);
        bus_read(CFG_ADDR, d);
        check("R2 field readback", d, 32'h29);
        bus_write(CFG_ADDR, 32'h0);
    endtask

    task automatic t_decode();
        @(negedge clk);
        probe(32'h0000_0000, 1'b1, 1'b1, 1'b0, "R3 bottom");
        probe(32'h0FFF_FFFC, 1'b1, 1'b1, 1'b0, "R3 top");
        probe(32'h1000_0000, 1'b1, 1'b0, 1'b0, "R4 above area");
        probe(32'h0000_0040, 1'b0, 1'b0, 1'b0, "R4 no valid");
        bus_write(CFG_ADDR, 32'h01);
        probe(32'h0000_0000, 1'b1, 1'b0, 1'b1, "R4 remapped");
        probe(32'h0FFF_FFFC, 1'b1, 1'b0, 1'b1, "R4 remapped top");
        probe(32'h2000_0000, 1'b1, 1'b0, 1'b0, "R4 remapped outside");
        bus_write(CFG_ADDR, 32'h00);
        probe(32'h0000_0010, 1'b1, 1'b1, 1'b0, "R5 restored");
        bus_write(CFG_ADDR, 32'h01);
        probe(32'h0000_0010, 1'b1, 1'b0, 1'b1, "R4 set again");
        bus_write(CFG_ADDR, 32'h00);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 active after request", {31'd0, core_idle}, 32'h0);
        repeat (3) @(negedge clk);
        check("R6 not idle after 3 quiet", {31'd0, core_idle}, 32'h0);
        @(negedge clk);
        check("R6 idle after 4 quiet", {31'd0, core_idle}, 32'h1);
    endtask

    task automatic t_wake();
        repeat (6) @(negedge clk);
        check("R6 still idle", {31'd0, core_idle}, 32'h1);
        req_valid = 1'b1; req_addr = 32'h4000_0000;
        #1;
        check("R7 grant while idle", {31'd0, req_grant}, 32'h1);
        check("R7 idle in request cycle", {31'd0, core_idle}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 active next edge", {31'd0, core_idle}, 32'h0);
    endtask

    task automatic t_keep_awake();
        repeat (6) @(negedge clk);
        check("R8 idle before keep", {31'd0, core_idle}, 32'h1);
        bus_write(CFG_ADDR, 32'h04);
        @(negedge clk);
        check("R8 woken by keep", {31'd0, core_idle}, 32'h0);
        repeat (10) @(negedge clk);
        check("R8 stays active", {31'd0, core_idle}, 32'h0);
        bus_write(CFG_ADDR, 32'h00);
    endtask

    task automatic t_pin_mux();
        @(negedge clk);
        sdram_clk_in = 1'b1; #1;
        check("R9 clock passes 1", {31'd0, sd_clk_pin}, 32'h1);
        sdram_clk_in = 1'b0; #1;
        check("R9 clock passes 0", {31'd0, sd_clk_pin}, 32'h0);
        bus_write(CFG_ADDR, 32'h0A);
        sdram_clk_in = 1'b0; #1;
        check("R9 level 1 on pin", {31'd0, sd_clk_pin}, 32'h1);
        bus_write(CFG_ADDR, 32'h08);
        sdram_clk_in = 1'b1; #1;
        check("R9 level 0 on pin", {31'd0, sd_clk_pin}, 32'h0);
        bus_write(CFG_ADDR, 32'h00);
    endtask

    task automatic t_enables();
        bus_write(CFG_ADDR, 32'h10);
        #1;
        check("R10 sdram_en on", {31'd0, sdram_en}, 32'h1);
        check("R10 jtag_en off", {31'd0, jtag_en}, 32'h0);
        bus_write(CFG_ADDR, 32'h20);
        #1;
        check("R10 sdram_en off", {31'd0, sdram_en}, 32'h0);
        check("R10 jtag_en on", {31'd0, jtag_en}, 32'h1);
        bus_write(CFG_ADDR, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_decode();
        t_idle();
        t_wake();
        t_keep_awake();
        t_pin_mux();
        t_enables();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule